// File: doc/BRIEF.md
# Per-Slave Bus Matrix Arbiter

This block decides which master of a multi-master, AHB-style bus matrix owns one slave port. Every master raises a request line toward the slave. The block watches the transfer currently on the slave port: its type, its burst kind and the ready signal. It moves ownership only at points where a move cannot break a transfer. The result is a registered grant, given both as a one-hot vector and as an index. Each slave port of the matrix gets its own instance, so each slave can use its own algorithm and its own default-master policy.

Configuration inputs set four things: the arbitration algorithm (round-robin or fixed priority), what happens when nobody requests the slave (release it, keep the last owner, or park it on a fixed master), the index of the parking master, and a slot limit. The slot limit bounds how many accepted beats one owner may take before it has to compete again. This limit matters for undefined-length bursts, which otherwise never reach a planned end.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant_valid` is 0, `grant_idx` is 0 and `grant` is all zeros.
- R2: The grant registers change only in the clock edge that follows a cycle where a re-arbitration point occurs. In any other cycle, `grant_valid` and `grant_idx` hold their values.
- R3: A cycle is a re-arbitration point when no master owns the slave or when `htrans` is 2'b00 (idle). `htrans` 2'b01 (busy) is neither a re-arbitration point nor a beat.
- R4: A cycle is a re-arbitration point when a beat is accepted (`htrans` is 2'b10 or 2'b11 and `hready` is 1) and `hburst` is 3'b000 (single).
- R5: For a fixed-length burst, the accepted beat in the last position is a re-arbitration point. `hburst` 3'b010 and 3'b011 have 4 beats, 3'b100 and 3'b101 have 8 beats, and 3'b110 and 3'b111 have 16 beats. A beat with `htrans` 2'b10 is at position 0. Each accepted 2'b11 beat is one position after the previous accepted beat.
- R6: An undefined-length burst (`hburst` 3'b001) is interrupted only by an idle cycle (R3) or by slot expiry (R7).
- R7: A slot counter counts accepted beats and is cleared at every re-arbitration point. The accepted beat that brings the count to `slot_limit` is a re-arbitration point. A `slot_limit` of 0 turns slot expiry off.
- R8: With `arb_fixed_prio` at 0 (round-robin), the search for a winner starts at the master after the last requesting winner and wraps around. After reset the search starts at master 0. Only a winner that was requesting updates the last-winner index.
- R9: With `arb_fixed_prio` at 1, the lowest-numbered requesting master wins. In both algorithms, a master that requests at a re-arbitration point is granted in preference to any default.
- R10: At a re-arbitration point with no requests, `default_mode` 2'b00 or 2'b11 (no default) clears `grant_valid`.
- R11: At a re-arbitration point with no requests, `default_mode` 2'b01 (last owner) leaves `grant_valid` and `grant_idx` unchanged.
- R12: At a re-arbitration point with no requests, `default_mode` 2'b10 (fixed) grants `default_idx` if it is below the number of masters. If it is not, the grant is cleared as for no default. `default_idx` has no effect in the other modes.
- R13: `grant` has only bit `grant_idx` set when `grant_valid` is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | One request line per master |
| htrans | input | 2 | Transfer type on the slave port: 00 idle, 01 busy, 10 nonsequential, 11 sequential |
| hburst | input | 3 | Burst kind of the current transfer |
| hready | input | 1 | The current beat is accepted |
| arb_fixed_prio | input | 1 | 0 selects round-robin, 1 selects fixed priority |
| default_mode | input | 2 | Policy applied when nobody requests the slave |
| default_idx | input | 4 | Index of the parking master for the fixed policy |
| slot_limit | input | SLOT_W | Maximum number of accepted beats per owner; 0 turns the limit off |
| grant | output | NUM_MASTERS | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted master |
| grant_valid | output | 1 | Some master is granted |

## Verification
The bench builds the block with NUM_MASTERS = 6 and SLOT_W = 4. With six masters, every `default_idx` from 6 to 15 is out of range, so the fallback of R12 gets exercised, and the round-robin wrap of R8 happens after only a few grants. A 4-bit slot counter lets short slot limits break undefined-length and fixed-length bursts often. It also lets the counter reach its saturation value of 15 during long runs with the limit off. The weighting of `htrans` gives enough consecutive sequential beats that 4-beat and 8-beat bursts reach their predicted end.

// File: rtl/slave_arb_pkg.sv
package slave_arb_pkg;

  localparam int BEAT_W = 5;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    DM_NONE  = 2'b00,
    DM_LAST  = 2'b01,
    DM_FIXED = 2'b10,
    DM_RSVD  = 2'b11
  } defmode_e;

  // number of beats of a burst kind; 0 marks the kinds with no planned end
  function automatic logic [BEAT_W-1:0] planned_beats(input logic [2:0] kind);
    logic [1:0] grp;
    if (kind < 3'd2) return '0;
    grp = 2'((kind - 3'd2) >> 1);
    return BEAT_W'(5'd4 << grp);
  endfunction

  function automatic logic is_fixed_len(input logic [2:0] kind);
    return kind >= 3'd2;
  endfunction

endpackage

// File: rtl/arb_boundary.sv
module arb_boundary #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owned,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              ev_idle,
  output logic              ev_single,
  output logic              ev_burst_end,
  output logic              ev_slot,
  output logic              rearb_ok
);
  import slave_arb_pkg::*;

  localparam logic [BEAT_W-1:0] BEAT_MAX = '1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [BEAT_W-1:0] beat_cnt;
  logic [BEAT_W-1:0] beat_pos;
  logic [SLOT_W-1:0] slot_cnt;
  logic [SLOT_W:0]   slot_after;
  logic              active;
  logic              accepted;

  assign active   = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);
  assign accepted = active && hready;
  assign beat_pos = (htrans == TR_NONSEQ) ? '0 : beat_cnt;

  assign ev_idle      = !owned || (htrans == TR_IDLE);
  assign ev_single    = accepted && (hburst == 3'b000);
  assign ev_burst_end = accepted && is_fixed_len(hburst) &&
                        (beat_pos == planned_beats(hburst) - 1'b1);
  assign slot_after   = {1'b0, slot_cnt} + 1'b1;
  assign ev_slot      = (slot_limit != '0) && accepted &&
                        (slot_after >= {1'b0, slot_limit});
  assign rearb_ok     = ev_idle || ev_single || ev_burst_end || ev_slot;

  // position inside the current burst, counted in accepted beats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (hready && htrans == TR_NONSEQ) begin
      beat_cnt <= BEAT_W'(1);
    end else if (hready && htrans == TR_SEQ && beat_cnt != BEAT_MAX) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  // accepted beats since the last arbitration point, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
    end else if (rearb_ok) begin
      slot_cnt <= '0;
    end else if (accepted && slot_cnt != SLOT_MAX) begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

  p_nonseq_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == TR_NONSEQ) |=> (beat_cnt == BEAT_W'(1)));

  p_slot_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rearb_ok |=> (slot_cnt == '0));

endmodule

// File: rtl/arb_picker.sv
module arb_picker #(
  parameter int NUM_MASTERS = 16,
  parameter int IDX_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]       last_idx,
  input  logic                   fixed_prio,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx
);

  logic             rr_valid;
  logic [IDX_W-1:0] rr_idx;
  logic             fp_valid;
  logic [IDX_W-1:0] fp_idx;

  // round-robin: scan offsets from far to near so the nearest one wins
  always_comb begin
    rr_valid = 1'b0;
    rr_idx   = '0;
    for (int off = NUM_MASTERS; off >= 1; off--) begin
      int cand;
      cand = int'(last_idx) + off;
      if (cand >= NUM_MASTERS) cand = cand - NUM_MASTERS;
      if (req[cand]) begin
        rr_valid = 1'b1;
        rr_idx   = IDX_W'(cand);
      end
    end
  end

  // fixed priority: scan from the top so the lowest index wins
  always_comb begin
    fp_valid = 1'b0;
    fp_idx   = '0;
    for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
      if (req[m]) begin
        fp_valid = 1'b1;
        fp_idx   = IDX_W'(m);
      end
    end
  end

  assign win_valid = fixed_prio ? fp_valid : rr_valid;
  assign win_idx   = fixed_prio ? fp_idx   : rr_idx;

  p_winner_requests_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req[win_idx]);

  p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_prio && win_valid) |->
      ((req & ((NUM_MASTERS'(1) << win_idx) - 1'b1)) == '0));

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter #(
  parameter int NUM_MASTERS = 16,
  parameter int SLOT_W      = 8,
  parameter int IDX_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [1:0]             htrans,
  input  logic [2:0]             hburst,
  input  logic                   hready,
  input  logic                   arb_fixed_prio,
  input  logic [1:0]             default_mode,
  input  logic [3:0]             default_idx,
  input  logic [SLOT_W-1:0]      slot_limit,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]       grant_idx,
  output logic                   grant_valid
);
  import slave_arb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_AT_RESET = IDX_W'(NUM_MASTERS - 1);

  logic             ev_idle, ev_single, ev_burst_end, ev_slot;
  logic             rearb_ok;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] last_idx;
  logic             park_in_range;
  logic             no_default;

  arb_boundary #(.SLOT_W(SLOT_W)) u_boundary (
    .clk          (clk),
    .rst_n        (rst_n),
    .owned        (grant_valid),
    .htrans       (htrans),
    .hburst       (hburst),
    .hready       (hready),
    .slot_limit   (slot_limit),
    .ev_idle      (ev_idle),
    .ev_single    (ev_single),
    .ev_burst_end (ev_burst_end),
    .ev_slot      (ev_slot),
    .rearb_ok     (rearb_ok)
  );

  arb_picker #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_picker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .last_idx   (last_idx),
    .fixed_prio (arb_fixed_prio),
    .win_valid  (win_valid),
    .win_idx    (win_idx)
  );

  assign park_in_range = int'(default_idx) < NUM_MASTERS;
  assign no_default    = (default_mode == DM_NONE) || (default_mode == DM_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      last_idx    <= LAST_AT_RESET;
    end else if (rearb_ok) begin
      if (win_valid) begin
        grant_valid <= 1'b1;
        grant_idx   <= win_idx;
        last_idx    <= win_idx;
      end else begin
        unique case (default_mode)
          DM_LAST: ;
          DM_FIXED: begin
            grant_valid <= park_in_range;
            if (park_in_range) grant_idx <= IDX_W'(default_idx);
          end
          default: grant_valid <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    grant = '0;
    if (grant_valid) grant[grant_idx] = 1'b1;
  end

  p_hold_between_points_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rearb_ok |=> ($stable(grant_valid) && $stable(grant_idx)));

  p_winner_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb_ok && win_valid) |=> (grant_valid && grant_idx == $past(win_idx)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb_ok && !win_valid && no_default) |=> !grant_valid);

  p_park_bad_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb_ok && !win_valid && default_mode == DM_FIXED && !park_in_range)
      |=> !grant_valid);

endmodule

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb_top;

  localparam int  NM       = 6;
  localparam int  SW       = 4;
  localparam int  IW       = 3;
  localparam time CLK_PER  = 10ns;
  localparam int  N_RANDOM = 6000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] req = '0;
  logic [1:0]    htrans = 2'b00;
  logic [2:0]    hburst = 3'b000;
  logic          hready = 1'b1;
  logic          arb_fixed_prio = 1'b0;
  logic [1:0]    default_mode = 2'b00;
  logic [3:0]    default_idx = 4'd0;
  logic [SW-1:0] slot_limit = '0;
  logic [NM-1:0] grant;
  logic [IW-1:0] grant_idx;
  logic          grant_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference state
  bit    m_valid = 1'b0;
  int    m_idx   = 0;
  int    m_last  = NM - 1;
  int    m_beat  = 0;
  int    m_slot  = 0;
  string m_tag   = "R1";

  always #(CLK_PER/2) clk = ~clk;

  slave_arbiter #(.NUM_MASTERS(NM), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .htrans(htrans), .hburst(hburst),
    .hready(hready), .arb_fixed_prio(arb_fixed_prio), .default_mode(default_mode),
    .default_idx(default_idx), .slot_limit(slot_limit), .grant(grant),
    .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  function automatic int beats_of(input logic [2:0] k);
    case (k)
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      3'd6, 3'd7: return 16;
      default:    return 0;
    endcase
  endfunction

  function automatic int rr_winner(input logic [NM-1:0] r, input int last);
    for (int step = 1; step <= NM; step++)
      if (r[(last + step) % NM]) return (last + step) % NM;
    return -1;
  endfunction

  function automatic int fp_winner(input logic [NM-1:0] r);
    for (int m = 0; m < NM; m++) if (r[m]) return m;
    return -1;
  endfunction

  // one clock edge of the reference, from the inputs held across it
  task automatic model_edge();
    bit    acc, p_idle, p_single, p_end, p_slot;
    int    pos, w;
    string why;
    acc      = htrans[1] && hready;
    pos      = (htrans == 2'b10) ? 0 : m_beat;
    p_idle   = !m_valid || htrans == 2'b00;
    p_single = acc && hburst == 3'b000;
    p_end    = acc && beats_of(hburst) != 0 && pos == beats_of(hburst) - 1;
    p_slot   = slot_limit != 0 && acc && (m_slot + 1) >= int'(slot_limit);
    if (p_idle) why = "R3";
    else if (p_single) why = "R4";
    else if (p_end) why = "R5";
    else if (p_slot) why = "R7";
    else why = (hburst == 3'b001) ? "R6" : "R2";
    if (p_idle || p_single || p_end || p_slot) begin
      w = arb_fixed_prio ? fp_winner(req) : rr_winner(req, m_last);
      if (w >= 0) begin
        m_valid = 1'b1; m_idx = w; m_last = w;
        why = {why, arb_fixed_prio ? " R9" : " R8"};
      end else if (default_mode == 2'b01) begin
        why = {why, " R11"};
      end else if (default_mode == 2'b10) begin
        why = {why, " R12"};
        if (int'(default_idx) < NM) begin m_valid = 1'b1; m_idx = int'(default_idx); end
        else m_valid = 1'b0;
      end else begin
        m_valid = 1'b0;
        why = {why, " R10"};
      end
      m_slot = 0;
    end else if (acc) begin
      m_slot = (m_slot + 1 > (1 << SW) - 1) ? (1 << SW) - 1 : m_slot + 1;
    end
    if (hready && htrans == 2'b10) m_beat = 1;
    else if (hready && htrans == 2'b11 && m_beat < 31) m_beat = m_beat + 1;
    m_tag = why;
  endtask

  task automatic check_outputs(input string tag);
    logic [NM-1:0] exp_g;
    exp_g = m_valid ? (NM'(1) << m_idx) : '0;
    n_checks++;
    if (grant_valid !== m_valid || (m_valid && int'(grant_idx) != m_idx)) begin
      n_fail++;
      $display("FAIL %s: valid/idx actual %0b/%0d expected %0b/%0d",
               tag, grant_valid, grant_idx, m_valid, m_idx);
    end
    n_checks++;
    if (grant !== exp_g) begin
      n_fail++;
      $display("FAIL R13: grant actual %b expected %b", grant, exp_g);
    end
  endtask

  task automatic step(input logic [NM-1:0] r, input logic [1:0] t,
                      input logic [2:0] b, input logic rdy);
    req = r; htrans = t; hburst = b; hready = rdy;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs(m_tag);
  endtask

  task automatic expect_grant(input bit v, input int idx, input string tag);
    n_checks++;
    if (grant_valid !== v || (v && int'(grant_idx) != idx)) begin
      n_fail++;
      $display("FAIL %s: directed actual %0b/%0d expected %0b/%0d",
               tag, grant_valid, grant_idx, v, idx);
    end
  endtask

  initial begin
    automatic int seed = 32'h5a17;
    automatic logic [2:0] cur_burst = 3'b000;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1");

    // fixed priority, lowest requester wins
    arb_fixed_prio = 1'b1; default_mode = 2'b00; slot_limit = '0;
    step(6'b001100, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b1, 2, "R9");
    // round-robin from last winner 2 wraps to 0, then resumes at 2
    arb_fixed_prio = 1'b0;
    step(6'b000101, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b1, 0, "R8");
    step(6'b000101, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b1, 2, "R8");
    // undefined-length burst is not broken by another request
    step(6'b000001, 2'b10, 3'b001, 1'b1);
    for (int i = 0; i < 9; i++) step(6'b000001, 2'b11, 3'b001, 1'b1);
    expect_grant(1'b1, 2, "R6");
    // busy is not an arbitration point
    step(6'b000001, 2'b01, 3'b001, 1'b1);
    expect_grant(1'b1, 2, "R3");
    // slot limit breaks the long burst
    slot_limit = SW'(3);
    step(6'b000001, 2'b11, 3'b001, 1'b1);
    expect_grant(1'b1, 0, "R7");
    // defaults with no requests
    default_mode = 2'b10; default_idx = 4'd9;
    step('0, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b0, 0, "R12");
    default_idx = 4'd4;
    step('0, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b1, 4, "R12");
    default_mode = 2'b01; default_idx = 4'd1;
    step('0, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b1, 4, "R11");
    default_mode = 2'b11;
    step('0, 2'b00, 3'b000, 1'b1);
    expect_grant(1'b0, 0, "R10");

    // constrained random traffic
    for (int n = 0; n < N_RANDOM; n++) begin
      automatic int pick = $urandom_range(99);
      automatic logic [1:0] t;
      if (n % 250 == 0) begin
        arb_fixed_prio = 1'($urandom_range(1));
        default_mode   = 2'($urandom_range(3));
        default_idx    = 4'($urandom_range(15));
        slot_limit     = ($urandom_range(2) == 0) ? '0 : SW'($urandom_range(15));
      end
      if (pick < 15) t = 2'b10;
      else if (pick < 75) t = 2'b11;
      else if (pick < 90) t = 2'b00;
      else t = 2'b01;
      if (t == 2'b10) cur_burst = 3'($urandom_range(7));
      step(($urandom_range(3) == 0) ? '0 : NM'($urandom), t, cur_burst,
           $urandom_range(3) != 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule